// File: doc/BRIEF.md
# Overflow-Triggered Sample Record Generator

This block holds four programmable event counters. Each one counts pulses from one line of an event bus. When a counter rolls over, it reloads from a preset value. If the counter is both enabled for sampling and programmed with a qualifying event selection, the rollover arms a capture. The first memory-class micro-op that retires after arming supplies a data linear address and a cache-hit indication. The retirement interface supplies two instruction addresses with it: the address of the instruction that caused the event and the address of the instruction that runs next.

The captured values go out as a fixed record of 23 words, each 64 bits wide, on a valid/ready stream. The words cover byte offsets 00H to 0B0H in ascending order. Back-pressure rules: once `rec_valid` is high, it stays high and `rec_data`/`rec_last` stay unchanged until a cycle in which `rec_ready` is also high, and exactly one word moves in that cycle. The sink may hold `rec_ready` low for any number of cycles. The block never drops a word and never emits one twice. While a record is pending, the block does not accept retirements.

Software programs the counters through a single-cycle write port. `cfg_addr[3:2]` selects the register kind: 0 = event select, 1 = preset, 2 = sampling enable. `cfg_addr[1:0]` selects the counter.

Top module: `sample_record_gen`

## Requirements
- R1: An event-select write takes `cfg_wdata[2:0]` as the event line. Each pulse on the selected line of `evt_i` raises the 8-bit counter by one. A preset write loads both the preset and the counter. A counter at preset P rolls over on pulse 256-P, reloads P, and rolls over again after another 256-P pulses. Rollover is the only condition that arms a sample.
- R2: A rollover arms a sample only when the counter's enable bit (`cfg_wdata[0]` of a kind-2 write) is 1 and bit 3 of its event select (the qualifying bit) is 1. Otherwise no record appears.
- R3: After arming, the first retirement with `ret_valid` and `ret_mem` both high is captured. Retirements with `ret_mem` low are ignored.
- R4: A record is 23 words for offsets 00H, 08H, ... 0B0H, sent in that order. `rec_last` is high only on the 0B0H word. Words not named in R5 to R7 are zero.
- R5: Word 08H holds `ret_next_ip`, word 98H holds `ret_lin_addr` and word 0B0H holds `ret_ip`, all taken from the captured retirement.
- R6: Bit 0 of word A0H is `ret_dcu_hit` when bit 4 of the firing counter's event select (store class) is 1, and all other bits are zero. For a load-class event the whole word is zero. Word A8H is always zero.
- R7: Word 00H carries the firing counter's index in bits [1:0], and all other bits are zero.
- R8: When several armed rollovers occur in the same cycle, the lowest-numbered counter gets its record first. Each of the others then gets its own record, in turn, from later retirements.
- R9: A qualifying rollover that occurs while a capture is armed or a record is being sent sets `lost_o`. `lost_o` stays high until reset. Such a rollover adds no record and does not change the record in flight.
- R10: While `rec_valid` is high and `rec_ready` is low, `rec_valid`, `rec_data` and `rec_last` hold their values into the next cycle.
- R11: After reset, `rec_valid` and `lost_o` are 0, every counter is 0, every preset is 0, and all enables and event selects are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 8 | Event pulse lines |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | [3:2] register kind, [1:0] counter |
| cfg_wdata | input | 8 | Register write data |
| ret_valid | input | 1 | A micro-op retires this cycle |
| ret_mem | input | 1 | Retiring micro-op is a load or store |
| ret_dcu_hit | input | 1 | Store hit the first-level data cache |
| ret_lin_addr | input | 64 | Data linear address of the retiring micro-op |
| ret_ip | input | 64 | Address of the retiring instruction |
| ret_next_ip | input | 64 | Address of the instruction that runs next |
| rec_valid | output | 1 | Record word valid |
| rec_ready | input | 1 | Sink accepts the record word |
| rec_data | output | 64 | Record word |
| rec_last | output | 1 | Final word of the record |
| lost_o | output | 1 | Sticky lost-sample flag |

## Verification
The assertions assume three things about the environment: the sink does not depend on the block to withdraw `rec_valid`, configuration writes never reprogram a counter while it is rolling over, and `evt_i` pulses are single cycles. The stimulus changes configuration only while the block is idle. It drives every input on the falling edge, raises event lines for one cycle at a time, and applies stall patterns through `rec_ready` alone. The sweep covers each counter with both event classes and several presets. For every record, the expected words are computed from the retirement values that the bench applied.

// File: rtl/sample_rec_pkg.sv
package sample_rec_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_EMIT} smp_state_e;

  localparam int REC_WORDS = 23;
  localparam int W_INDEX   = 0;
  localparam int W_NEXT_IP = 1;
  localparam int W_LIN     = 19;
  localparam int W_STATUS  = 20;
  localparam int W_EV_IP   = 22;

  localparam logic [1:0] K_EVSEL  = 2'd0;
  localparam logic [1:0] K_PRESET = 2'd1;
  localparam logic [1:0] K_ENABLE = 2'd2;
endpackage

// File: rtl/smp_event_counter.sv
module smp_event_counter
  import sample_rec_pkg::*;
#(
  parameter int CW  = 8,
  parameter int NEV = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_i,
  input  logic           wr_sel_i,
  input  logic           wr_preset_i,
  input  logic           wr_en_i,
  input  logic [CW-1:0]  wdata_i,
  output logic           sample_o,
  output logic           store_cls_o
);
  localparam int LW  = (NEV > 1) ? $clog2(NEV) : 1;
  localparam int ESW = LW + 2;

  logic [ESW-1:0] sel_q;
  logic [CW-1:0]  cnt_q, preset_q;
  logic           en_q, hit, ovf;

  assign hit = evt_i[sel_q[LW-1:0]];
  assign ovf = hit && (cnt_q == {CW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      cnt_q    <= '0;
      preset_q <= '0;
      en_q     <= 1'b0;
    end else begin
      if (wr_sel_i) sel_q <= wdata_i[ESW-1:0];
      if (wr_en_i)  en_q  <= wdata_i[0];
      if (wr_preset_i) begin
        preset_q <= wdata_i;
        cnt_q    <= wdata_i;
      end else if (ovf) begin
        cnt_q <= preset_q;
      end else if (hit) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sample_o    = ovf && en_q && sel_q[LW];
  assign store_cls_o = sel_q[LW+1];

  p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !wr_preset_i) |=> (cnt_q == $past(preset_q)));
  p_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ovf && !wr_preset_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/smp_arbiter.sv
module smp_arbiter #(
  parameter int NCNT = 4,
  localparam int IW  = (NCNT > 1) ? $clog2(NCNT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCNT-1:0] sample_vec_i,
  input  logic            busy_i,
  output logic            take_o,
  output logic [NCNT-1:0] grant_o,
  output logic [IW-1:0]   grant_idx_o,
  output logic            lost_o
);
  logic [NCNT-1:0] pend_q;
  logic            lost_q;

  always_comb begin
    grant_o     = '0;
    grant_idx_o = '0;
    for (int i = NCNT - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        grant_o     = '0;
        grant_o[i]  = 1'b1;
        grant_idx_o = IW'(i);
      end
    end
  end

  assign take_o = !busy_i && (|pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      lost_q <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~(take_o ? grant_o : '0)) | (busy_i ? '0 : sample_vec_i);
      lost_q <= lost_q | (busy_i && (|sample_vec_i));
    end
  end

  assign lost_o = lost_q;

  p_grant_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  p_grant_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o) |-> ((pend_q & (grant_o - 1'b1)) == '0));
  p_lost_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |=> lost_q);
endmodule

// File: rtl/smp_emitter.sv
module smp_emitter
  import sample_rec_pkg::*;
#(
  parameter int DW = 64,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [IW-1:0] idx_i,
  input  logic          store_cls_i,
  input  logic          ret_valid_i,
  input  logic          ret_mem_i,
  input  logic          ret_hit_i,
  input  logic [DW-1:0] ret_lin_i,
  input  logic [DW-1:0] ret_ip_i,
  input  logic [DW-1:0] ret_nip_i,
  input  logic          rec_ready_i,
  output logic          busy_o,
  output logic          rec_valid_o,
  output logic [DW-1:0] rec_data_o,
  output logic          rec_last_o
);
  localparam int WIW = $clog2(REC_WORDS);
  localparam logic [WIW-1:0] LAST_W = WIW'(REC_WORDS - 1);

  smp_state_e     state_q;
  logic [WIW-1:0] widx_q;
  logic [IW-1:0]  idx_q;
  logic           cls_q, sts_q;
  logic [DW-1:0]  lin_q, ip_q, nip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      widx_q  <= '0;
      idx_q   <= '0;
      cls_q   <= 1'b0;
      sts_q   <= 1'b0;
      lin_q   <= '0;
      ip_q    <= '0;
      nip_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (take_i) begin
          idx_q   <= idx_i;
          cls_q   <= store_cls_i;
          state_q <= ST_ARMED;
        end
        ST_ARMED: if (ret_valid_i && ret_mem_i) begin
          lin_q   <= ret_lin_i;
          ip_q    <= ret_ip_i;
          nip_q   <= ret_nip_i;
          sts_q   <= cls_q && ret_hit_i;
          widx_q  <= '0;
          state_q <= ST_EMIT;
        end
        ST_EMIT: if (rec_ready_i) begin
          if (widx_q == LAST_W) state_q <= ST_IDLE;
          else                  widx_q  <= widx_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rec_data_o = '0;
    case (widx_q)
      WIW'(W_INDEX):   rec_data_o = DW'(idx_q);
      WIW'(W_NEXT_IP): rec_data_o = nip_q;
      WIW'(W_LIN):     rec_data_o = lin_q;
      WIW'(W_STATUS):  rec_data_o = DW'(sts_q);
      WIW'(W_EV_IP):   rec_data_o = ip_q;
      default:         rec_data_o = '0;
    endcase
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign rec_valid_o = (state_q == ST_EMIT);
  assign rec_last_o  = rec_valid_o && (widx_q == LAST_W);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && !rec_ready_i) |=>
      (rec_valid_o && $stable(rec_data_o) && $stable(rec_last_o)));
  p_load_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid_o && (widx_q == WIW'(W_STATUS)) && !cls_q) |-> (rec_data_o == '0));
endmodule

// File: rtl/sample_record_gen.sv
module sample_record_gen
  import sample_rec_pkg::*;
#(
  parameter int NCNT = 4,
  parameter int CW   = 8,
  parameter int NEV  = 8,
  parameter int DW   = 64,
  localparam int IW  = (NCNT > 1) ? $clog2(NCNT) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_i,
  input  logic           cfg_we,
  input  logic [IW+1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_wdata,
  input  logic           ret_valid,
  input  logic           ret_mem,
  input  logic           ret_dcu_hit,
  input  logic [DW-1:0]  ret_lin_addr,
  input  logic [DW-1:0]  ret_ip,
  input  logic [DW-1:0]  ret_next_ip,
  output logic           rec_valid,
  input  logic           rec_ready,
  output logic [DW-1:0]  rec_data,
  output logic           rec_last,
  output logic           lost_o
);
  logic [1:0]      kind;
  logic [IW-1:0]   cidx;
  logic [NCNT-1:0] sample_vec, store_vec, grant;
  logic [IW-1:0]   grant_idx;
  logic            take, busy;

  assign kind = cfg_addr[IW+1:IW];
  assign cidx = cfg_addr[IW-1:0];

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic hit_me;
    assign hit_me = cfg_we && (cidx == IW'(g));
    smp_event_counter #(.CW(CW), .NEV(NEV)) i_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt_i),
      .wr_sel_i    (hit_me && (kind == K_EVSEL)),
      .wr_preset_i (hit_me && (kind == K_PRESET)),
      .wr_en_i     (hit_me && (kind == K_ENABLE)),
      .wdata_i     (cfg_wdata),
      .sample_o    (sample_vec[g]),
      .store_cls_o (store_vec[g])
    );
  end

  smp_arbiter #(.NCNT(NCNT)) i_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_vec_i (sample_vec),
    .busy_i       (busy),
    .take_o       (take),
    .grant_o      (grant),
    .grant_idx_o  (grant_idx),
    .lost_o       (lost_o)
  );

  smp_emitter #(.DW(DW), .IW(IW)) i_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (take),
    .idx_i       (grant_idx),
    .store_cls_i (|(grant & store_vec)),
    .ret_valid_i (ret_valid),
    .ret_mem_i   (ret_mem),
    .ret_hit_i   (ret_dcu_hit),
    .ret_lin_i   (ret_lin_addr),
    .ret_ip_i    (ret_ip),
    .ret_nip_i   (ret_next_ip),
    .rec_ready_i (rec_ready),
    .busy_o      (busy),
    .rec_valid_o (rec_valid),
    .rec_data_o  (rec_data),
    .rec_last_o  (rec_last)
  );
endmodule

// File: tb/test_sample_record_gen.sv
module test_sample_record_gen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  evt = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        ret_valid = 1'b0, ret_mem = 1'b0, ret_dcu_hit = 1'b0;
  logic [63:0] ret_lin_addr = '0, ret_ip = '0, ret_next_ip = '0;
  logic        rec_valid, rec_ready = 1'b0, rec_last, lost;
  logic [63:0] rec_data;
  int nchk = 0, nerr = 0;

  always #(CLK_P/2) clk = ~clk;

  sample_record_gen i_sample_record_gen (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ret_valid(ret_valid), .ret_mem(ret_mem),
    .ret_dcu_hit(ret_dcu_hit), .ret_lin_addr(ret_lin_addr), .ret_ip(ret_ip),
    .ret_next_ip(ret_next_ip), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_data(rec_data), .rec_last(rec_last), .lost_o(lost)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int idx, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'((kind << 2) | idx); cfg_wdata = 8'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulses(input logic [7:0] mask, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt = mask;
      @(negedge clk); evt = '0;
    end
  endtask

  task automatic retire(input bit mem, input bit hit, input logic [63:0] lin,
                        input logic [63:0] ip, input logic [63:0] nip);
    @(negedge clk);
    @(negedge clk);
    ret_valid = 1'b1; ret_mem = mem; ret_dcu_hit = hit;
    ret_lin_addr = lin; ret_ip = ip; ret_next_ip = nip;
    @(negedge clk);
    ret_valid = 1'b0; ret_mem = 1'b0; ret_dcu_hit = 1'b0;
  endtask

  task automatic quiet(input string req);
    bit seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (rec_valid) seen = 1;
    end
    chk(req, 64'(seen), 64'd0);
  endtask

  function automatic string tag(input int w);
    if (w == 0) return "R7 index word";
    if (w == 1 || w == 19 || w == 22) return "R5 address word";
    if (w == 20 || w == 21) return "R6 status/reserved word";
    return "R4 zero word";
  endfunction

  task automatic get_record(input int ci, input bit st, input bit hit,
                            input logic [63:0] lin, input logic [63:0] ip,
                            input logic [63:0] nip, input bit stall);
    logic [63:0] exp [23];
    logic [63:0] held = '0;
    bit stalled = 0, rdy;
    int w = 0, guard = 0, ph = 0;
    for (int k = 0; k < 23; k++) exp[k] = '0;
    exp[0]  = 64'(ci);
    exp[1]  = nip;
    exp[19] = lin;
    exp[20] = st ? 64'(hit) : 64'd0;
    exp[22] = ip;
    while (w < 23 && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (stalled) begin
        chk("R10 valid held", 64'(rec_valid), 64'd1);
        chk("R10 data held", rec_data, held);
      end
      if (rec_valid) begin
        rdy = stall ? (ph % 3 == 2) : 1'b1;
        ph++;
        if (rdy) begin
          chk(tag(w), rec_data, exp[w]);
          chk("R4 last flag", 64'(rec_last), 64'(w == 22));
          w++;
          stalled = 0;
        end else begin
          stalled = 1;
          held = rec_data;
        end
        rec_ready = rdy;
      end else begin
        rec_ready = 1'b0;
        stalled = 0;
      end
    end
    @(negedge clk);
    rec_ready = 1'b0;
    chk("R4 word count", 64'(w), 64'd23);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [63:0] lin, ip;
    repeat (3) @(negedge clk);
    chk("R11 reset valid", 64'(rec_valid), 64'd0);
    chk("R11 reset lost", 64'(lost), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 valid after reset", 64'(rec_valid), 64'd0);

    // R11/R1: counter starts at zero, rolls over on the 256th pulse
    wr(0, 0, 8'h08); wr(2, 0, 1);
    pulses(8'h01, 255);
    retire(1, 0, 64'h1, 64'h2, 64'h3);
    quiet("R1 no rollover before 256 pulses");
    pulses(8'h01, 1);
    retire(1, 1, 64'hAAAA_0000_0000_0040, 64'h0000_7000_0000_1000, 64'h0000_7000_0000_1004);
    get_record(0, 0, 1, 64'hAAAA_0000_0000_0040, 64'h0000_7000_0000_1000,
               64'h0000_7000_0000_1004, 0);
    wr(2, 0, 0);

    // Sweep: each counter, both classes, preset and reload (R1, R3, R4-R7, R10)
    for (int ci = 0; ci < 4; ci++) begin
      for (int st = 0; st < 2; st++) begin
        int n = 3 + ci + st;
        wr(0, ci, ci | 8 | (st << 4));
        wr(1, ci, 256 - n);
        wr(2, ci, 1);
        for (int pass = 0; pass < 2; pass++) begin
          bit hit = 1'(ci + pass);
          lin = 64'hDA7A_0000_0000_0000 | 64'(ci << 8) | 64'(st << 4) | 64'(pass);
          ip  = 64'h0040_1000_0000_0000 | 64'(ci << 12) | 64'(st << 8) | 64'(pass << 4);
          pulses(8'(1 << ci), n - 1);
          retire(1, 1, 64'h5, 64'h6, 64'h7);
          quiet("R1 count before rollover");
          pulses(8'(1 << ci), 1);
          retire(0, ~hit, 64'hBAD0, 64'hBAD1, 64'hBAD2);
          retire(1, hit, lin, ip, ip + 64'd4);
          get_record(ci, 1'(st), hit, lin, ip, ip + 64'd4, 1'(st ^ pass));
        end
        wr(2, ci, 0);
      end
    end

    // R2: not qualifying, then qualifying but disabled
    wr(0, 2, 8'h02); wr(1, 2, 8'hFE); wr(2, 2, 1);
    pulses(8'h04, 2);
    retire(1, 0, 64'h11, 64'h12, 64'h13);
    quiet("R2 unqualified event");
    wr(0, 2, 8'h0A); wr(2, 2, 0); wr(1, 2, 8'hFE);
    pulses(8'h04, 2);
    retire(1, 0, 64'h21, 64'h22, 64'h23);
    quiet("R2 sampling disabled");

    // R8: counters 1 and 3 roll over together
    wr(0, 1, 8'h0D); wr(1, 1, 8'hFE); wr(2, 1, 1);
    wr(0, 3, 8'h1D); wr(1, 3, 8'hFE); wr(2, 3, 1);
    pulses(8'h20, 2);
    retire(1, 1, 64'h0000_0000_00C0_0010, 64'hF100, 64'hF104);
    get_record(1, 0, 1, 64'h0000_0000_00C0_0010, 64'hF100, 64'hF104, 0);
    retire(1, 1, 64'h0000_0000_00C0_0020, 64'hF200, 64'hF208);
    get_record(3, 1, 1, 64'h0000_0000_00C0_0020, 64'hF200, 64'hF208, 0);
    quiet("R8 no third record");
    wr(2, 1, 0); wr(2, 3, 0);
    chk("R9 lost clear before overflow during emit", 64'(lost), 64'd0);

    // R9: rollover during emission
    wr(0, 0, 8'h08); wr(1, 0, 8'hFE); wr(2, 0, 1);
    wr(0, 2, 8'h0A); wr(1, 2, 8'hFE); wr(2, 2, 1);
    pulses(8'h01, 2);
    retire(1, 0, 64'h0000_BEEF_0000_0008, 64'hE000, 64'hE004);
    for (int i = 0; i < 20 && !rec_valid; i++) @(negedge clk);
    pulses(8'h04, 2);
    @(negedge clk);
    chk("R9 lost set", 64'(lost), 64'd1);
    get_record(0, 0, 0, 64'h0000_BEEF_0000_0008, 64'hE000, 64'hE004, 1);
    retire(1, 1, 64'h77, 64'h78, 64'h79);
    quiet("R9 no record for lost sample");
    chk("R9 lost sticky", 64'(lost), 64'd1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule